// File: doc/BRIEF.md
# Bit-17 Page Swap Fixup Engine

This engine repairs the contents of a buffer whose pages may have been moved to new physical frames. Each page is 4096 bytes. When a page now sits at a physical address whose bit 17 differs from the value recorded earlier for that page, the page is rewritten: inside every 128-byte chunk, the first and second 64-byte halves change places. In the other mode the engine records bit 17 of every page's current physical address into an internal per-page bitmap, so that a later fixup pass has a reference to compare against.

The caller gives a page count and a start pulse. The engine walks a page list by driving an index and reading back that page's physical address on the same cycle. All data movement goes through one 64-bit memory port with a valid/ready request channel and a response strobe. When the pass ends the engine raises a one-cycle done pulse and reports how many pages it rewrote.

Top module: `bf17_fixup_engine`

## Requirements
- R1: While reset is high and right after it, `busy`, `done`, `mem_req_valid` and `dirty_pages` are all 0, and no bitmap is recorded.
- R2: `start` is accepted only while `busy` is low. `busy` is high in the cycle after an accepted start. A `start` seen while busy, including the cycle in which `done` is high, has no effect.
- R3: With `start_save`=1 (save mode) the engine visits indexes 0 to `page_count`-1 in order, one per cycle. It stores `pl_addr[17]` of each entry as that index's bitmap bit and issues no memory request. `done` comes `page_count` cycles after the first busy cycle, and the bitmap is then marked recorded.
- R4: With `start_save`=0 (fixup mode) and no bitmap recorded since reset, the engine issues no request, `done` is high in the cycle right after the start, and `dirty_pages` is 0.
- R5: In fixup mode, page i is rewritten only when `pl_addr[17]` of list entry i differs from bitmap bit i. `dirty_pages` equals the number of pages rewritten in the pass.
- R6: A rewrite exchanges bytes 0..63 with bytes 64..127 of each of the 32 chunks of the page at byte address `{pl_addr[31:12], 12'h000}`, in ascending chunk order. A second fixup pass with the same list and an unchanged bitmap restores the original contents.
- R7: Accesses are 64-bit words at byte address chunk base + 8*j. Per chunk the order is: 8 reads of the low half (j = 0..7); then, for j = 0..7, a read of high word j followed by a write of that data to low word j; then 8 writes of the saved low words to high words j = 0..7. No request is issued while a read response is outstanding.
- R8: A request that is not accepted (`mem_req_ready` low) stays valid with its write flag, address and data unchanged.
- R9: `done` is high for exactly one cycle. `dirty_pages` holds its value until the next accepted start, which clears it.
- R10: A start with `page_count`=0 completes with `done` in the cycle after the start and no memory request, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| start_save | input | 1 | 1 = record bitmap, 0 = fixup pass |
| page_count | input | CNT_W | Number of list entries to process (values above MAX_PAGES are clamped) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| dirty_pages | output | CNT_W | Pages rewritten in the last pass |
| pl_idx | output | IDX_W | Page-list index being looked up |
| pl_addr | input | ADDR_W | Physical address of entry `pl_idx`, same cycle |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address of the 64-bit word |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data strobe for the outstanding read |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
Two functions can coincide in one cycle: the end-of-pass pulse and a fresh start command. The bench raises `start` in exactly the cycle where `done` is observed high and then requires `busy` to stay low with the dirty count unchanged. It also injects a save-mode start in the middle of a long fixup pass while memory back-pressure is random. A behavioural model builds the full ordered list of expected word accesses before each pass and compares every accepted request against it, so a start taken during either of these events would show up as a wrong or missing request, or a wrong count.

// File: rtl/bf17_pkg.sv
package bf17_pkg;

    // Geometry of the data being repaired
    localparam int PAGE_BYTES      = 4096;
    localparam int CHUNK_BYTES     = 128;
    localparam int HALF_BYTES      = CHUNK_BYTES / 2;
    localparam int PAGE_SHIFT      = $clog2(PAGE_BYTES);
    localparam int CHUNKS_PER_PAGE = PAGE_BYTES / CHUNK_BYTES;
    localparam int CHUNK_W         = $clog2(CHUNKS_PER_PAGE);

    // Physical address bit whose change forces a rewrite
    localparam int TAG_BIT = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_RD_LO,
        ST_RD_HI,
        ST_WR_LO,
        ST_WR_HI,
        ST_FIN
    } seq_state_e;

    typedef enum logic {
        MODE_FIXUP = 1'b0,
        MODE_SAVE  = 1'b1
    } run_mode_e;

    function automatic int half_words(input int data_w);
        return HALF_BYTES / (data_w / 8);
    endfunction

endpackage

// File: rtl/bf17_bitmap.sv
module bf17_bitmap #(
    parameter int MAX_PAGES = 16,
    localparam int IDX_W = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             seal,
    output logic             rd_bit,
    output logic             recorded
);

    logic [MAX_PAGES-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits     <= '0;
            recorded <= 1'b0;
        end else begin
            if (wr_en) bits[idx] <= wr_bit;
            if (seal)  recorded  <= 1'b1;
        end
    end

    assign rd_bit = bits[idx];

    // R3
    recorded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        recorded |=> recorded);

endmodule

// File: rtl/bf17_hold.sv
module bf17_hold #(
    parameter int DATA_W = 64,
    parameter int WORDS  = 8,
    localparam int W_IDX = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [W_IDX-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [W_IDX-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (wr_en && wr_idx == W_IDX'(g))
                slot[g] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/bf17_seq.sv
module bf17_seq
    import bf17_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int MAX_PAGES = 16,
    localparam int CNT_W    = $clog2(MAX_PAGES + 1),
    localparam int IDX_W    = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
    localparam int HWORDS   = half_words(DATA_W),
    localparam int WORD_W   = $clog2(HWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_save,
    input  logic [CNT_W-1:0]  page_count,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  dirty_pages,
    output logic [IDX_W-1:0]  pl_idx,
    input  logic [ADDR_W-1:0] pl_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              bm_wr_en,
    output logic              bm_wr_bit,
    output logic              bm_seal,
    input  logic              bm_rd_bit,
    input  logic              bm_recorded,
    output logic              hold_wr_en,
    output logic [WORD_W-1:0] hold_idx,
    input  logic [DATA_W-1:0] hold_rd_data
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int PFN_W  = ADDR_W - PAGE_SHIFT;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    seq_state_e         st;
    run_mode_e          mode;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   page_idx;
    logic [CNT_W-1:0]   dirty_cnt;
    logic [PFN_W-1:0]   pfn;
    logic [CHUNK_W-1:0] chunk;
    logic [WORD_W-1:0]  word;
    logic               wait_rsp;
    logic [DATA_W-1:0]  stage;

    logic [CNT_W-1:0]   count_in;
    logic               tag_now;
    logic               rewrite;
    logic               hs;
    logic               rsp_take;
    logic               word_last;
    logic               chunk_last;
    logic               page_last;
    logic               page_end;
    logic               upper_half;
    logic               rd_phase;
    req_t               req;
    logic               pl_low_unused;

    assign pl_low_unused = ^pl_addr[PAGE_SHIFT-1:0];

    assign count_in   = (page_count > CNT_W'(MAX_PAGES)) ? CNT_W'(MAX_PAGES) : page_count;
    assign tag_now    = pl_addr[TAG_BIT];
    assign rewrite    = (st == ST_PAGE) && (mode == MODE_FIXUP) && (tag_now != bm_rd_bit);
    assign word_last  = (word == WORD_W'(HWORDS - 1));
    assign chunk_last = (chunk == CHUNK_W'(CHUNKS_PER_PAGE - 1));
    assign page_last  = ((page_idx + CNT_W'(1)) == count);
    assign upper_half = (st == ST_RD_HI) || (st == ST_WR_HI);
    assign rd_phase   = (st == ST_RD_LO) || (st == ST_RD_HI);

    always_comb begin
        req.we   = (st == ST_WR_LO) || (st == ST_WR_HI);
        req.addr = {pfn, chunk, upper_half, word, {BYTE_W{1'b0}}};
        req.data = (st == ST_WR_LO) ? stage : hold_rd_data;
    end

    assign mem_req_valid = req.we || (rd_phase && !wait_rsp);
    assign mem_req_we    = req.we;
    assign mem_req_addr  = req.addr;
    assign mem_req_wdata = req.data;

    assign hs       = mem_req_valid && mem_req_ready;
    assign rsp_take = wait_rsp && mem_rsp_valid;
    assign page_end = ((st == ST_PAGE) && !rewrite) ||
                      ((st == ST_WR_HI) && hs && word_last && chunk_last);

    // Side interfaces
    assign pl_idx     = page_idx[IDX_W-1:0];
    assign bm_wr_en   = (st == ST_PAGE) && (mode == MODE_SAVE);
    assign bm_wr_bit  = tag_now;
    assign bm_seal    = (st == ST_FIN) && (mode == MODE_SAVE);
    assign hold_wr_en = (st == ST_RD_LO) && rsp_take;
    assign hold_idx   = word;

    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_FIN);
    assign dirty_pages = dirty_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            mode      <= MODE_FIXUP;
            count     <= '0;
            page_idx  <= '0;
            dirty_cnt <= '0;
            pfn       <= '0;
            chunk     <= '0;
            word      <= '0;
            wait_rsp  <= 1'b0;
            stage     <= '0;
        end else begin
            if (hs && !req.we) wait_rsp <= 1'b1;
            if (rsp_take)      wait_rsp <= 1'b0;

            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        mode      <= start_save ? MODE_SAVE : MODE_FIXUP;
                        count     <= count_in;
                        page_idx  <= '0;
                        dirty_cnt <= '0;
                        if (count_in == '0 || (!start_save && !bm_recorded))
                            st <= ST_FIN;
                        else
                            st <= ST_PAGE;
                    end
                end
                ST_PAGE: begin
                    if (rewrite) begin
                        pfn       <= pl_addr[ADDR_W-1:PAGE_SHIFT];
                        chunk     <= '0;
                        word      <= '0;
                        dirty_cnt <= dirty_cnt + CNT_W'(1);
                        st        <= ST_RD_LO;
                    end
                end
                ST_RD_LO: begin
                    if (rsp_take) begin
                        word <= word + WORD_W'(1);
                        if (word_last) st <= ST_RD_HI;
                    end
                end
                ST_RD_HI: begin
                    if (rsp_take) begin
                        stage <= mem_rsp_rdata;
                        st    <= ST_WR_LO;
                    end
                end
                ST_WR_LO: begin
                    if (hs) begin
                        word <= word + WORD_W'(1);
                        st   <= word_last ? ST_WR_HI : ST_RD_HI;
                    end
                end
                ST_WR_HI: begin
                    if (hs) begin
                        word <= word + WORD_W'(1);
                        if (word_last) begin
                            chunk <= chunk + CHUNK_W'(1);
                            st    <= ST_RD_LO;
                        end
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase

            if (page_end) begin
                if (page_last) begin
                    st <= ST_FIN;
                end else begin
                    page_idx <= page_idx + CNT_W'(1);
                    st       <= ST_PAGE;
                end
            end
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R3
    save_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SAVE) |-> !mem_req_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    dirty_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(dirty_pages));

    // R7
    rsp_phase_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_take |-> rd_phase);

    // R5
    always_comb begin
        if (!rst) dirty_bound_chk: assert (dirty_cnt <= count);
    end

endmodule

// File: rtl/bf17_fixup_engine.sv
module bf17_fixup_engine
    import bf17_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int MAX_PAGES = 16,
    localparam int CNT_W    = $clog2(MAX_PAGES + 1),
    localparam int IDX_W    = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_save,
    input  logic [CNT_W-1:0]  page_count,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  dirty_pages,
    output logic [IDX_W-1:0]  pl_idx,
    input  logic [ADDR_W-1:0] pl_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    localparam int HWORDS = half_words(DATA_W);
    localparam int WORD_W = $clog2(HWORDS);

    logic              bm_wr_en;
    logic              bm_wr_bit;
    logic              bm_seal;
    logic              bm_rd_bit;
    logic              bm_recorded;
    logic              hold_wr_en;
    logic [WORD_W-1:0] hold_idx;
    logic [DATA_W-1:0] hold_rd_data;

    bf17_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAX_PAGES (MAX_PAGES)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .start_save    (start_save),
        .page_count    (page_count),
        .busy          (busy),
        .done          (done),
        .dirty_pages   (dirty_pages),
        .pl_idx        (pl_idx),
        .pl_addr       (pl_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .bm_wr_en      (bm_wr_en),
        .bm_wr_bit     (bm_wr_bit),
        .bm_seal       (bm_seal),
        .bm_rd_bit     (bm_rd_bit),
        .bm_recorded   (bm_recorded),
        .hold_wr_en    (hold_wr_en),
        .hold_idx      (hold_idx),
        .hold_rd_data  (hold_rd_data)
    );

    bf17_bitmap #(
        .MAX_PAGES (MAX_PAGES)
    ) u_bitmap (
        .clk      (clk),
        .rst      (rst),
        .idx      (pl_idx),
        .wr_en    (bm_wr_en),
        .wr_bit   (bm_wr_bit),
        .seal     (bm_seal),
        .rd_bit   (bm_rd_bit),
        .recorded (bm_recorded)
    );

    bf17_hold #(
        .DATA_W (DATA_W),
        .WORDS  (HWORDS)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hold_wr_en),
        .wr_idx  (hold_idx),
        .wr_data (mem_rsp_rdata),
        .rd_idx  (hold_idx),
        .rd_data (hold_rd_data)
    );

endmodule

// File: tb/test_bf17_fixup_engine.sv
module test_bf17_fixup_engine;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 64;
    localparam int MAX_PAGES = 16;
    localparam int CNT_W     = $clog2(MAX_PAGES + 1);
    localparam int IDX_W     = $clog2(MAX_PAGES);

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              start_save;
    logic [CNT_W-1:0]  page_count;
    logic              busy;
    logic              done;
    logic [CNT_W-1:0]  dirty_pages;
    logic [IDX_W-1:0]  pl_idx;
    logic [ADDR_W-1:0] pl_addr;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic              mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid;
    logic [DATA_W-1:0] mem_rsp_rdata;

    logic [ADDR_W-1:0] page_tab [MAX_PAGES];

    always #5 clk = ~clk;

    assign pl_addr = page_tab[pl_idx];

    bf17_fixup_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAX_PAGES (MAX_PAGES)
    ) i_bf17_fixup_engine (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .start_save    (start_save),
        .page_count    (page_count),
        .busy          (busy),
        .done          (done),
        .dirty_pages   (dirty_pages),
        .pl_idx        (pl_idx),
        .pl_addr       (pl_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [63:0] data;
    } txn_t;

    txn_t        exp_q [$];
    logic [63:0] mem [logic [31:0]];
    bit          model_bm [MAX_PAGES];
    bit          model_rec;
    int          checks;
    int          fails;

    function automatic logic [63:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a, ~a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: expected ordered accesses for one pass
    task automatic build(input bit save, input int cnt, output int exp_dirty);
        int n;
        n = (cnt > MAX_PAGES) ? MAX_PAGES : cnt;
        exp_dirty = 0;
        exp_q.delete();
        if (save) begin
            for (int i = 0; i < n; i++) model_bm[i] = page_tab[i][17];
            model_rec = 1'b1;
        end else if (model_rec) begin
            for (int i = 0; i < n; i++) begin
                if (page_tab[i][17] != model_bm[i]) begin
                    logic [31:0] base;
                    exp_dirty++;
                    base = {page_tab[i][31:12], 12'h000};
                    for (int c = 0; c < 32; c++) begin
                        logic [31:0] cb;
                        cb = base + 32'(c * 128);
                        for (int w = 0; w < 8; w++)
                            exp_q.push_back('{1'b0, cb + 32'(8 * w), 64'h0});
                        for (int w = 0; w < 8; w++) begin
                            exp_q.push_back('{1'b0, cb + 32'(64 + 8 * w), 64'h0});
                            exp_q.push_back('{1'b1, cb + 32'(8 * w), mem_rd(cb + 32'(64 + 8 * w))});
                        end
                        for (int w = 0; w < 8; w++)
                            exp_q.push_back('{1'b1, cb + 32'(64 + 8 * w), mem_rd(cb + 32'(8 * w))});
                    end
                end
            end
        end
    endtask

    // Memory model and per-clock request comparison
    initial begin : mem_model
        int          delay;
        logic [31:0] pend_a;
        bit          stalled;
        logic        st_we;
        logic [31:0] st_addr;
        logic [63:0] st_data;
        txn_t        t;
        delay = -1;
        pend_a = '0;
        stalled = 1'b0;
        st_we = 1'b0;
        st_addr = '0;
        st_data = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (stalled) begin
                // R8: stalled request must persist unchanged
                chk(mem_req_valid && mem_req_we == st_we && mem_req_addr == st_addr &&
                    mem_req_wdata == st_data, "R8", "stalled request changed",
                    {31'b0, mem_req_we, mem_req_addr}, {31'b0, st_we, st_addr});
            end
            mem_rsp_valid = 1'b0;
            if (delay == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem_rd(pend_a);
                delay = -1;
            end else if (delay > 0) begin
                delay--;
            end
            mem_req_ready = ($urandom_range(3) != 0);
            stalled = !rst && mem_req_valid && !mem_req_ready;
            st_we = mem_req_we;
            st_addr = mem_req_addr;
            st_data = mem_req_wdata;
            if (!rst && mem_req_valid && mem_req_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected request", {32'h0, mem_req_addr}, 64'h0);
                end else begin
                    t = exp_q.pop_front();
                    chk(mem_req_we == t.we && mem_req_addr == t.addr, "R7", "request kind/address",
                        {31'b0, mem_req_we, mem_req_addr}, {31'b0, t.we, t.addr});
                    if (t.we)
                        chk(mem_req_wdata == t.data, "R6", "write data", mem_req_wdata, t.data);
                end
                if (mem_req_we) begin
                    mem[mem_req_addr] = mem_req_wdata;
                end else begin
                    chk(delay < 0, "R7", "read issued while one outstanding", 64'(delay), 64'hFFFF_FFFF_FFFF_FFFF);
                    pend_a = mem_req_addr;
                    delay = $urandom_range(2);
                end
            end
        end
    end

    task automatic run(input bit save, input int cnt, input bit poke_busy,
                       input bit poke_done, input string tag);
        int               exp_dirty;
        bit               imm;
        int               cyc;
        logic [CNT_W-1:0] held;
        imm = (cnt == 0) || (!save && !model_rec);
        build(save, cnt, exp_dirty);
        @(negedge clk);
        start = 1'b1;
        start_save = save;
        page_count = CNT_W'(cnt);
        @(negedge clk);
        start = 1'b0;
        if (imm)
            chk(done === 1'b1, tag, "done in cycle after start", {63'b0, done}, 64'h1);
        else
            chk(busy === 1'b1 && done === 1'b0, "R2", "busy after accepted start", {63'b0, busy}, 64'h1);
        cyc = 0;
        while (done !== 1'b1) begin
            if (poke_busy && cyc == 40) begin
                // R2: start while busy must be ignored
                start = 1'b1;
                start_save = 1'b1;
                page_count = CNT_W'(1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (save && cnt > 0)
            chk(cyc == cnt, "R3", "cycles to done", 64'(cyc), 64'(cnt));
        chk(dirty_pages == CNT_W'(exp_dirty), tag, "dirty count", 64'(dirty_pages), 64'(exp_dirty));
        chk(exp_q.size() == 0, "R7", "requests still expected", 64'(exp_q.size()), 64'h0);
        held = dirty_pages;
        if (poke_done) begin
            // R2: start in the done cycle
            start = 1'b1;
            start_save = 1'b0;
            page_count = CNT_W'(4);
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b0 && done === 1'b0, "R2", "start during done taken",
                {62'b0, busy, done}, 64'h0);
        end else begin
            @(negedge clk);
            chk(done === 1'b0, "R9", "done longer than one cycle", {63'b0, done}, 64'h0);
        end
        repeat (3) @(negedge clk);
        chk(dirty_pages == held && busy === 1'b0, "R9", "dirty count held", 64'(dirty_pages), 64'(held));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog run hung actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        checks = 0;
        fails = 0;
        model_rec = 1'b0;
        for (int i = 0; i < MAX_PAGES; i++) begin
            model_bm[i] = 1'b0;
            page_tab[i] = 32'h0100_0000 + 32'(i * 4096);
        end
        page_tab[0] = 32'h0002_0000;
        page_tab[1] = 32'h0001_3000;
        page_tab[2] = 32'h0006_5000;
        page_tab[3] = 32'h0000_8000;
        rst = 1'b1;
        start = 1'b0;
        start_save = 1'b0;
        page_count = '0;
        repeat (3) @(negedge clk);
        // R1
        chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0 && dirty_pages == '0,
            "R1", "reset state", {61'b0, busy, done, mem_req_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && dirty_pages == '0, "R1", "after reset", 64'(dirty_pages), 64'h0);

        // R4: fixup with nothing recorded
        run(1'b0, 4, 1'b0, 1'b0, "R4");
        // R3: record bitmap; also a start during the done cycle (R2)
        run(1'b1, 4, 1'b0, 1'b1, "R3");
        // R5: no bit changed, nothing rewritten
        run(1'b0, 4, 1'b0, 1'b0, "R5");

        // Move pages 1 and 2 so their bit 17 flips
        page_tab[1] = 32'h0003_3000;
        page_tab[2] = 32'h0004_5000;
        // R5/R6/R7 with a start injected mid-pass (R2)
        run(1'b0, 4, 1'b1, 1'b0, "R5");
        chk(mem_rd(32'h0003_3000) == {32'h0003_3040, ~32'h0003_3040}, "R6", "page1 chunk0 low",
            mem_rd(32'h0003_3000), {32'h0003_3040, ~32'h0003_3040});
        chk(mem_rd(32'h0003_3FF8) == {32'h0003_3FB8, ~32'h0003_3FB8}, "R6", "page1 last chunk high",
            mem_rd(32'h0003_3FF8), {32'h0003_3FB8, ~32'h0003_3FB8});
        chk(mem_rd(32'h0004_5040) == {32'h0004_5000, ~32'h0004_5000}, "R6", "page2 chunk0 high",
            mem_rd(32'h0004_5040), {32'h0004_5000, ~32'h0004_5000});
        chk(!mem.exists(32'h0002_0000), "R5", "page0 untouched", 64'(mem.exists(32'h0002_0000)), 64'h0);

        // R6: second pass restores original contents
        run(1'b0, 4, 1'b0, 1'b0, "R6");
        chk(mem_rd(32'h0003_3000) == {32'h0003_3000, ~32'h0003_3000}, "R6", "page1 restored",
            mem_rd(32'h0003_3000), {32'h0003_3000, ~32'h0003_3000});

        // R10: zero pages, both modes; start clears previous count (R9)
        run(1'b0, 0, 1'b0, 1'b0, "R10");
        run(1'b1, 0, 1'b0, 1'b0, "R10");

        // R3: re-record, then nothing to repair
        run(1'b1, 4, 1'b0, 1'b0, "R3");
        run(1'b0, 4, 1'b0, 1'b0, "R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule